// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out a single elementary NAND bus operation at a time on behalf of a host. The host sees a small word-addressed space: a page buffer RAM holding four independent buffers, and six registers for the command byte, the address byte, the buffer selection, the configuration, the control/trigger and the ECC result. Writing a one-hot code to the control register starts an operation. The engine then drives a simplified NAND pin set of latch enables, write and read strobes, chip enable, ready/busy and an 8-bit data bus. It latches a command or an address byte, streams a buffer out to the flash, fills a buffer from the flash, reads the device ID or reads the status byte.

Every bus strobe lasts one clock. Completion is reported through a sticky flag in bit 15 of the control register and an interrupt line that the configuration can mask. A transfer covers either a whole buffer (512 main bytes, then 16 spare bytes) or, in spare-only mode, just the 16 spare bytes. ECC is not computed here. The block holds the result of an external ECC unit in a register and raises an uncorrectable flag from it.

Host word map (word addresses): buffer words 0x000-0x41F (word w holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8); 0x800 command byte, 0x801 address byte, 0x802 buffer select (bits 1:0), 0x803 configuration, 0x804 control, 0x805 ECC result. Read data appears one clock after the address.

Top module: `nand_op_engine`

## Requirements
- R1: The control register's bits 5:0 start an operation only when exactly one bit is set: 0x01 command cycle, 0x02 address cycle, 0x04 program from buffer, 0x08 fill buffer from flash, 0x10 read ID, 0x20 read status. Codes that are not one-hot, and any trigger written while an operation runs, start nothing.
- R2: A command cycle is one clock with the command latch high, the write strobe low and the command byte on the bus. An address cycle is the same but raises the address latch and drives the address byte.
- R3: Control bit 15 is set when an operation ends and stays set until the host writes the control register with bit 15 at 0. The interrupt output equals that flag while configuration bit 4 (mask) is 0, and is 0 while the mask is 1.
- R4: Buffer n's main area occupies bytes n*512 to n*512+511. Its spare area occupies bytes 0x800+n*16 to 0x800+n*16+15.
- R5: A full program drives 528 write strobes: the selected buffer's main bytes, then its spare bytes, in ascending order. The completion flag is not set before ready/busy is high after the last byte.
- R6: With configuration bit 2 (spare-only) set, program and fill operations move only the 16 spare bytes of the selected buffer and leave its main area untouched.
- R7: A fill operation issues no read strobe and does not complete while ready/busy is low. It then stores the k-th byte read at transfer position k, in the same order as R5.
- R8: Read status takes one byte and writes the selected buffer's first main word with the status in bits 7:0 and zero in bits 15:8. Other words are unchanged.
- R9: Read ID takes 6 bytes. With configuration bit 1 (16-bit device) at 0, they fill main bytes 0 to 5. With it at 1, byte k goes to bits 7:0 of main word k and bits 15:8 are zero.
- R10: The ECC result register reads the spare result in bits 1:0 and the main result in bits 3:2. The uncorrectable output is high when configuration bit 3 (ECC enable) is 1 and either field equals 2.
- R11: Chip enable (active low) is asserted while an operation runs and whenever configuration bit 7 (force enable) is 1. Otherwise it is deasserted.
- R12: After reset, all registers read zero, strobes and latches are inactive, chip enable is deasserted and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hwr | input | 1 | Host write strobe |
| haddr | input | 12 | Host word address |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data, one clock after haddr |
| irq | output | 1 | Completion interrupt |
| ecc_main_res | input | 2 | Main-area result from the ECC unit |
| ecc_spare_res | input | 2 | Spare-area result from the ECC unit |
| ecc_fail | output | 1 | Uncorrectable error indication |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb | input | 1 | Ready (1) / busy (0) |
| nf_io_in | input | 8 | Flash data bus, inbound |
| nf_io_out | output | 8 | Flash data bus, outbound |
| nf_io_oe | output | 1 | Outbound bus drive enable |

## Verification
The assertions assume the flash model never answers a read strobe with a write of its own. They also assume that ready/busy changes only between operations or inside the waits the engine makes for it, so the strobe and latch checks see the engine's own sequencing alone. The bench drives the bus from a model that updates on the falling edge, and it moves ready/busy only while the engine is idle or parked in a wait. Every host access goes through one write or one read per two clocks, so the control register is never hit at the edge where an operation ends, except in the deliberate busy-trigger case.

// File: rtl/nand_op_engine.sv
module nand_op_engine #(
  parameter int NUM_BUFS    = 4,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 6,
  parameter int HA_W        = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hwr,
  input  logic [HA_W-1:0] haddr,
  input  logic [15:0]     hwdata,
  output logic [15:0]     hrdata,
  output logic            irq,
  input  logic [1:0]      ecc_main_res,
  input  logic [1:0]      ecc_spare_res,
  output logic            ecc_fail,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_ce_n,
  output logic            nf_we_n,
  output logic            nf_re_n,
  input  logic            nf_rb,
  input  logic [7:0]      nf_io_in,
  output logic [7:0]      nf_io_out,
  output logic            nf_io_oe
);
  localparam int XFER_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int TOT_BYTES  = NUM_BUFS * XFER_BYTES;
  localparam int WORDS      = TOT_BYTES / 2;
  localparam int SPARE_BASE = NUM_BUFS * MAIN_BYTES;
  localparam int BS_W       = $clog2(NUM_BUFS);
  localparam int BA_W       = $clog2(TOT_BYTES);
  localparam int WA_W       = BA_W - 1;
  localparam int IX_W       = $clog2(XFER_BYTES + 1);

  localparam logic [5:0] OP_CMD = 6'h01, OP_ADR = 6'h02, OP_PROG = 6'h04,
                         OP_FILL = 6'h08, OP_ID = 6'h10, OP_STAT = 6'h20;

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_XFER, S_WAIT} st_t;

  st_t              st;
  logic [5:0]       op_q;
  logic [IX_W-1:0]  idx;
  logic             done_q;
  logic [7:0]       cmd_q, adr_q, cfg_q;
  logic [BS_W-1:0]  bsel_q;

  logic [7:0] mem_lo [WORDS];
  logic [7:0] mem_hi [WORDS];

  wire reg_sel = haddr[HA_W-1];
  wire [2:0] reg_idx = haddr[2:0];
  wire [WA_W-1:0] hword = haddr[WA_W-1:0];
  wire hword_ok = haddr[HA_W-2:0] < (HA_W-1)'(WORDS);
  wire ctrl_wr = hwr & reg_sel & (reg_idx == 3'd4);
  wire [5:0] trig = hwdata[5:0];
  wire one_hot = (trig != 6'd0) && ((trig & (trig - 6'd1)) == 6'd0);
  wire start = ctrl_wr & (st == S_IDLE) & one_hot;
  wire spare_only = cfg_q[2];
  wire wide_dev = cfg_q[1];

  wire [IX_W-1:0] start_idx =
    (spare_only && (trig == OP_PROG || trig == OP_FILL)) ? IX_W'(MAIN_BYTES) : '0;

  logic [IX_W-1:0] last_idx;
  always_comb begin
    case (op_q)
      OP_ID:   last_idx = IX_W'(ID_BYTES - 1);
      OP_STAT: last_idx = '0;
      default: last_idx = IX_W'(XFER_BYTES - 1);
    endcase
  end

  wire [BA_W-1:0] main_ba = BA_W'(bsel_q) * BA_W'(MAIN_BYTES);
  logic [BA_W-1:0] xfer_ba;
  always_comb begin
    if (idx < IX_W'(MAIN_BYTES))
      xfer_ba = main_ba + BA_W'(idx);
    else
      xfer_ba = BA_W'(SPARE_BASE) + BA_W'(bsel_q) * BA_W'(SPARE_BYTES)
              + BA_W'(idx - IX_W'(MAIN_BYTES));
  end

  wire in_xfer = (st == S_XFER);
  wire rd_xfer = in_xfer & (op_q != OP_PROG);

  logic [WA_W-1:0] ew_word;
  logic            ew_lo_en, ew_hi_en;
  logic [7:0]      ew_lo;
  always_comb begin
    ew_word  = xfer_ba[BA_W-1:1];
    ew_lo_en = rd_xfer & ~xfer_ba[0];
    ew_hi_en = rd_xfer & xfer_ba[0];
    ew_lo    = nf_io_in;
    if (op_q == OP_STAT) begin
      ew_word  = main_ba[BA_W-1:1];
      ew_lo_en = rd_xfer;
      ew_hi_en = rd_xfer;
    end else if (op_q == OP_ID && wide_dev) begin
      ew_word  = main_ba[BA_W-1:1] + WA_W'(idx);
      ew_lo_en = rd_xfer;
      ew_hi_en = rd_xfer;
    end
  end
  wire [7:0] ew_hi = ((op_q == OP_STAT) || (op_q == OP_ID && wide_dev)) ? 8'h00 : nf_io_in;

  always_ff @(posedge clk) begin
    if (ew_lo_en || ew_hi_en) begin
      if (ew_lo_en) mem_lo[ew_word] <= ew_lo;
      if (ew_hi_en) mem_hi[ew_word] <= ew_hi;
    end else if (hwr && !reg_sel && hword_ok) begin
      mem_lo[hword] <= hwdata[7:0];
      mem_hi[hword] <= hwdata[15:8];
    end
  end

  wire [7:0] prog_byte = xfer_ba[0] ? mem_hi[xfer_ba[BA_W-1:1]] : mem_lo[xfer_ba[BA_W-1:1]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      idx    <= '0;
      done_q <= 1'b0;
      cmd_q  <= '0;
      adr_q  <= '0;
      cfg_q  <= '0;
      bsel_q <= '0;
    end else begin
      if (hwr && reg_sel) begin
        case (reg_idx)
          3'd0: cmd_q  <= hwdata[7:0];
          3'd1: adr_q  <= hwdata[7:0];
          3'd2: bsel_q <= hwdata[BS_W-1:0];
          3'd3: cfg_q  <= hwdata[7:0];
          default: ;
        endcase
      end
      if (ctrl_wr && !hwdata[15]) done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= trig;
          idx  <= start_idx;
          case (trig)
            OP_CMD, OP_ADR:  st <= S_STRB;
            OP_FILL, OP_ID:  st <= S_WAIT;
            default:         st <= S_XFER;
          endcase
        end
        S_STRB: begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        S_WAIT: if (nf_rb) begin
          if (op_q == OP_PROG) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_XFER;
          end
        end
        S_XFER: begin
          idx <= idx + 1'b1;
          if (idx == last_idx) begin
            if (op_q == OP_PROG) st <= S_WAIT;
            else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hrdata <= '0;
    else if (reg_sel) begin
      case (reg_idx)
        3'd0: hrdata <= {8'h00, cmd_q};
        3'd1: hrdata <= {8'h00, adr_q};
        3'd2: hrdata <= 16'(bsel_q);
        3'd3: hrdata <= {8'h00, cfg_q};
        3'd4: hrdata <= {done_q, 9'd0, (st != S_IDLE) ? op_q : 6'd0};
        3'd5: hrdata <= {12'd0, ecc_main_res, ecc_spare_res};
        default: hrdata <= '0;
      endcase
    end else if (hword_ok) hrdata <= {mem_hi[hword], mem_lo[hword]};
    else hrdata <= '0;
  end

  assign nf_cle    = (st == S_STRB) && (op_q == OP_CMD);
  assign nf_ale    = (st == S_STRB) && (op_q == OP_ADR);
  assign nf_we_n   = !((st == S_STRB) || (in_xfer && op_q == OP_PROG));
  assign nf_re_n   = !rd_xfer;
  assign nf_io_oe  = !nf_we_n;
  assign nf_io_out = (st == S_STRB) ? ((op_q == OP_CMD) ? cmd_q : adr_q) : prog_byte;
  assign nf_ce_n   = !((st != S_IDLE) || cfg_q[7]);
  assign irq       = done_q & ~cfg_q[4];
  assign ecc_fail  = cfg_q[3] & ((ecc_main_res == 2'd2) | (ecc_spare_res == 2'd2));
endmodule

// File: rtl/nand_op_engine_chk.sv
module nand_op_engine_chk #(
  parameter int HA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hwr,
  input logic [HA_W-1:0] haddr,
  input logic [15:0]     hwdata,
  input logic            done_q,
  input logic            nf_cle,
  input logic            nf_ale,
  input logic            nf_ce_n,
  input logic            nf_we_n,
  input logic            nf_re_n,
  input logic            nf_io_oe
);
  wire flag_clear = hwr && haddr[HA_W-1] && (haddr[2:0] == 3'd4) && !hwdata[15];

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  assert_latch_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_cle || nf_ale) |=> !(nf_cle || nf_ale));

  assert_latches_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  assert_ce_during_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !flag_clear) |=> done_q);

  assert_bus_released_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe);
endmodule

bind nand_op_engine nand_op_engine_chk #(.HA_W(HA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hwr(hwr), .haddr(haddr), .hwdata(hwdata),
  .done_q(done_q), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_oe(nf_io_oe)
);

// File: tb/nand_op_engine_tb_top.sv
`timescale 1ns/1ps
module nand_op_engine_tb_top;
  localparam logic [11:0] A_CMD = 12'h800, A_ADR = 12'h801, A_BSEL = 12'h802,
                          A_CFG = 12'h803, A_CTRL = 12'h804, A_ECC = 12'h805;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hwr = 1'b0;
  logic [11:0] haddr = '0;
  logic [15:0] hwdata = '0;
  logic [15:0] hrdata;
  logic irq, ecc_fail;
  logic [1:0] ecc_m = '0, ecc_s = '0;
  logic nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_io_oe;
  logic nf_rb = 1'b1;
  logic [7:0] nf_io_in = '0;
  logic [7:0] nf_io_out;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, cle_cnt = 0, ale_cnt = 0;
  logic [7:0] cle_byte = '0, ale_byte = '0;
  logic [7:0] wr_cap [1024];

  always #4 clk = ~clk;

  nand_op_engine dut_i (
    .clk(clk), .rst_n(rst_n), .hwr(hwr), .haddr(haddr), .hwdata(hwdata),
    .hrdata(hrdata), .irq(irq), .ecc_main_res(ecc_m), .ecc_spare_res(ecc_s),
    .ecc_fail(ecc_fail), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb(nf_rb), .nf_io_in(nf_io_in),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe)
  );

  function automatic logic [7:0] dev_byte(input int n);
    return 8'((n * 37 + 91) & 255);
  endfunction
  function automatic logic [7:0] hp(input int a);
    return 8'((a * 11 + (a >> 7) * 3 + 5) & 255);
  endfunction

  always @(negedge clk) begin
    if (!nf_re_n) begin
      nf_io_in <= dev_byte(rd_cnt);
      rd_cnt <= rd_cnt + 1;
    end
    if (!nf_we_n) begin
      if (nf_cle) begin cle_cnt <= cle_cnt + 1; cle_byte <= nf_io_out; end
      else if (nf_ale) begin ale_cnt <= ale_cnt + 1; ale_byte <= nf_io_out; end
      else begin wr_cap[wr_cnt % 1024] <= nf_io_out; wr_cnt <= wr_cnt + 1; end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); hwr = 1'b1; haddr = a; hwdata = d;
    @(negedge clk); hwr = 1'b0;
  endtask
  task automatic host_rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); hwr = 1'b0; haddr = a;
    @(negedge clk); d = hrdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_done(input string what);
    logic [15:0] d;
    for (int i = 0; i < 3000; i++) begin
      host_rd(A_CTRL, d);
      if (d[15]) return;
    end
    check(1'b0, what, 0, 1);
  endtask
  task automatic run_op(input logic [15:0] code, input string what);
    host_wr(A_CTRL, code);
    wait_done(what);
  endtask
  function automatic int buf_byte(input int b, input int k);
    return (k < 512) ? b * 512 + k : 2048 + b * 16 + (k - 512);
  endfunction

  initial begin
    logic [15:0] d;
    int base, bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R12 reset state
    host_rd(A_CTRL, d); check(d == 16'h0, "R12 control after reset", d, 0);
    host_rd(A_CFG, d);  check(d == 16'h0, "R12 config after reset", d, 0);
    host_rd(A_CMD, d);  check(d == 16'h0, "R12 command after reset", d, 0);
    check({irq, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale} == 6'b011100,
          "R12 pins after reset", {irq, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 6'b011100);

    // R2 command and address cycles
    foreach (d[i]) if (i < 5) begin
      logic [7:0] c;
      c = 8'(i * 61 + 3);
      base = cle_cnt;
      host_wr(A_CMD, {8'h00, c});
      run_op(16'h0001, "R2 command done");
      check(cle_cnt == base + 1, "R2 one command strobe", cle_cnt - base, 1);
      check(cle_byte == c, "R2 command byte", cle_byte, c);
      base = ale_cnt;
      host_wr(A_ADR, {8'h00, ~c});
      run_op(16'h0002, "R2 address done");
      check(ale_cnt == base + 1, "R2 one address strobe", ale_cnt - base, 1);
      check(ale_byte == ~c, "R2 address byte", ale_byte, ~c);
    end

    // R3 sticky flag and interrupt mask
    check(irq == 1'b1, "R3 irq with flag set", irq, 1);
    host_wr(A_CTRL, 16'h8000);
    host_rd(A_CTRL, d); check(d[15] == 1'b1, "R3 flag kept by write of 1", d[15], 1);
    host_wr(A_CFG, 16'h0010); idle(1);
    check(irq == 1'b0, "R3 irq masked", irq, 0);
    host_wr(A_CFG, 16'h0000); idle(1);
    check(irq == 1'b1, "R3 irq unmasked", irq, 1);
    host_wr(A_CTRL, 16'h0000);
    host_rd(A_CTRL, d); check(d[15] == 1'b0, "R3 flag cleared", d[15], 0);
    check(irq == 1'b0, "R3 irq after clear", irq, 0);

    // R1 non-one-hot codes start nothing
    foreach (d[i]) if (i < 4) begin
      logic [15:0] code;
      code = (i == 0) ? 16'h0003 : (i == 1) ? 16'h0000 : (i == 2) ? 16'h0030 : 16'h003F;
      base = cle_cnt + ale_cnt + wr_cnt + rd_cnt;
      host_wr(A_CTRL, code); idle(20);
      host_rd(A_CTRL, d);
      check(d == 16'h0, "R1 invalid code ignored (control)", d, 0);
      check(cle_cnt + ale_cnt + wr_cnt + rd_cnt == base, "R1 invalid code ignored (bus)",
            cle_cnt + ale_cnt + wr_cnt + rd_cnt - base, 0);
    end

    // R4 fill all buffers through the host port
    for (int w = 0; w < 1056; w++) host_wr(12'(w), {hp(2 * w + 1), hp(2 * w)});
    host_rd(12'h41F, d); check(d == {hp(2111), hp(2110)}, "R4 host word readback", d, {hp(2111), hp(2110)});

    // R5 full program of every buffer, R1 busy trigger, R11 CE while busy
    for (int b = 0; b < 4; b++) begin
      host_wr(A_BSEL, 16'(b));
      nf_rb = 1'b0;
      base = wr_cnt;
      host_wr(A_CTRL, 16'h0004);
      if (b == 0) begin
        int cb;
        cb = cle_cnt;
        host_wr(A_CMD, 16'h0055);
        host_wr(A_CTRL, 16'h0001);
        idle(4);
        check(cle_cnt == cb, "R1 trigger while busy ignored", cle_cnt - cb, 0);
      end
      for (int t = 0; t < 2000 && wr_cnt < base + 528; t++) @(negedge clk);
      idle(10);
      host_rd(A_CTRL, d);
      check(d[15] == 1'b0, "R5 no completion while busy", d[15], 0);
      check(nf_ce_n == 1'b0, "R11 chip enable while running", nf_ce_n, 0);
      nf_rb = 1'b1;
      wait_done("R5 program done");
      check(wr_cnt == base + 528, "R5 write strobe count", wr_cnt - base, 528);
      bad = 0;
      for (int k = 0; k < 528; k++) if (wr_cap[(base + k) % 1024] != hp(buf_byte(b, k))) bad++;
      check(bad == 0, "R5 R4 program byte order", bad, 0);
    end

    // R6 spare-only program
    host_wr(A_CFG, 16'h0004);
    host_wr(A_BSEL, 16'd2);
    base = wr_cnt;
    run_op(16'h0004, "R6 spare program done");
    check(wr_cnt == base + 16, "R6 spare-only strobe count", wr_cnt - base, 16);
    bad = 0;
    for (int k = 0; k < 16; k++) if (wr_cap[(base + k) % 1024] != hp(2048 + 32 + k)) bad++;
    check(bad == 0, "R6 spare-only bytes", bad, 0);

    // R7 full fill of buffer 1 with busy hold-off
    host_wr(A_CFG, 16'h0000);
    host_wr(A_BSEL, 16'd1);
    nf_rb = 1'b0;
    base = rd_cnt;
    host_wr(A_CTRL, 16'h0008);
    idle(30);
    check(rd_cnt == base, "R7 no read strobe while busy", rd_cnt - base, 0);
    host_rd(A_CTRL, d); check(d[15] == 1'b0, "R7 no completion while busy", d[15], 0);
    nf_rb = 1'b1;
    wait_done("R7 fill done");
    check(rd_cnt == base + 528, "R7 read strobe count", rd_cnt - base, 528);
    bad = 0;
    for (int w = 0; w < 264; w++) begin
      int k0, a0;
      k0 = (w < 256) ? 2 * w : 512 + 2 * (w - 256);
      a0 = buf_byte(1, k0);
      host_rd(12'(a0 / 2), d);
      if (d != {dev_byte(base + k0 + 1), dev_byte(base + k0)}) bad++;
    end
    check(bad == 0, "R7 R4 fill placement", bad, 0);

    // R6 spare-only fill of buffer 3
    host_wr(A_CFG, 16'h0004);
    host_wr(A_BSEL, 16'd3);
    base = rd_cnt;
    run_op(16'h0008, "R6 spare fill done");
    check(rd_cnt == base + 16, "R6 spare fill strobe count", rd_cnt - base, 16);
    bad = 0;
    for (int j = 0; j < 8; j++) begin
      host_rd(12'((2048 + 48) / 2 + j), d);
      if (d != {dev_byte(base + 2 * j + 1), dev_byte(base + 2 * j)}) bad++;
    end
    check(bad == 0, "R6 spare fill bytes", bad, 0);
    host_rd(12'h300, d); check(d == {hp(1537), hp(1536)}, "R6 main area untouched", d, {hp(1537), hp(1536)});

    // R8 read status into buffer 2
    host_wr(A_CFG, 16'h0000);
    host_wr(A_BSEL, 16'd2);
    base = rd_cnt;
    run_op(16'h0020, "R8 status done");
    check(rd_cnt == base + 1, "R8 single read strobe", rd_cnt - base, 1);
    host_rd(12'h200, d); check(d == {8'h00, dev_byte(base)}, "R8 status word", d, {8'h00, dev_byte(base)});
    host_rd(12'h201, d); check(d == {hp(1027), hp(1026)}, "R8 next word untouched", d, {hp(1027), hp(1026)});

    // R9 read ID, byte-packed then word-spread
    host_wr(A_BSEL, 16'd0);
    base = rd_cnt;
    run_op(16'h0010, "R9 id done");
    bad = 0;
    for (int w = 0; w < 3; w++) begin
      host_rd(12'(w), d);
      if (d != {dev_byte(base + 2 * w + 1), dev_byte(base + 2 * w)}) bad++;
    end
    check(bad == 0, "R9 id narrow placement", bad, 0);
    host_rd(12'd3, d); check(d == {hp(7), hp(6)}, "R9 word after id untouched", d, {hp(7), hp(6)});
    host_wr(A_CFG, 16'h0002);
    base = rd_cnt;
    run_op(16'h0010, "R9 id wide done");
    bad = 0;
    for (int w = 0; w < 6; w++) begin
      host_rd(12'(w), d);
      if (d != {8'h00, dev_byte(base + w)}) bad++;
    end
    check(bad == 0, "R9 id wide placement", bad, 0);
    host_wr(A_CTRL, 16'h0000);

    // R10 ECC result register sweep
    for (int en = 0; en < 2; en++) begin
      host_wr(A_CFG, en ? 16'h0008 : 16'h0000);
      for (int v = 0; v < 16; v++) begin
        logic expf;
        ecc_m = 2'(v >> 2); ecc_s = 2'(v);
        host_rd(A_ECC, d);
        check(d == 16'(v), "R10 result register", d, v);
        expf = (en == 1) && ((v >> 2) == 2 || (v & 3) == 2);
        check(ecc_fail == expf, "R10 uncorrectable flag", ecc_fail, expf);
      end
    end

    // R11 forced chip enable
    host_wr(A_CFG, 16'h0080); idle(1);
    check(nf_ce_n == 1'b0, "R11 forced enable", nf_ce_n, 0);
    host_wr(A_CFG, 16'h0000); idle(1);
    check(nf_ce_n == 1'b1, "R11 enable released when idle", nf_ce_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule